// File: doc/BRIEF.md
# Framed Serial Command Port Slave

This block is the slave end of a synchronous serial command link. A single serial clock times every pin. The master shifts 16-bit words in on a data pin, most significant bit first. A strobe marks frame boundaries. The strobe is high while the last bit of the previous frame is on the pin, so the first bit of a new frame is sampled on the clock edge after the one that samples the strobe. Frames may run back to back, or a frame may end with no strobe, after which the port waits for the next strobe.

Each complete word is classified by its top bit. A control word either writes an 8-bit value into a small register bank or asks for a register to be returned. A returned value goes out as a 16-bit frame on a separate read data pin, with its own strobe that follows the same convention. A transmit data word is not stored. It is passed downstream as a one-cycle strobe that carries a 5-bit address, two mode flags and a data byte. If a strobe arrives before all 16 bits of a frame are in, that frame is dropped.

Top module: `cmd_port_slave`

## Requirements
- R1: While rst_ni is low and right after it is released, regs_o is all zero and tx_valid_o, rd_fs_o and rd_dat_o are low.
- R2: A word is 16 bits shifted MSB first on cmd_dat_i. Its MSB is sampled on the edge after the edge that sees cmd_fs_i high. cmd_fs_i may be high with bit 0 of one frame to start the next frame at once.
- R3: Bit 15 of a word selects the kind: 0 is a control word, 1 is a transmit data word.
- R4: A control word with bit 14 = 0 writes bits 7:0 into the register at address bits 13:8. The register is held in regs_o[8*a+7:8*a], and the new value shows there from the second edge after the edge that samples bit 0.
- R5: A transmit data word raises tx_valid_o for exactly one cycle, starting at the edge after the one that samples bit 0. During that cycle tx_addr_o = bits 14:10, tx_updn_o = bit 9, tx_mode_o = bit 8 and tx_data_o = bits 7:0. No register changes.
- R6: A control word with bit 14 = 1 produces a response frame {1'b0, 1'b1, addr[5:0], value[7:0]}. rd_fs_o is high for one cycle starting at the second edge after bit 0 is sampled. The 16 response bits follow on rd_dat_o, MSB first, one per cycle, starting one cycle after rd_fs_o. A response that follows another at once has its rd_fs_o high during the previous response's last bit.
- R7: rd_dat_o is low whenever no response bit is being sent. A read does not change any register, and a transmit data word never triggers a response.
- R8: When cmd_fs_i arrives before the 16th bit of a frame, that frame has no effect (no write, no strobe, no response), and the next frame starts on the following edge.
- R9: Register addresses at or above NUM_REGS are ignored on write, and reads of them return the value 0.
- R10: Bits shifted in after a frame has ended, with no new strobe, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_dat_i | input | 1 | Command serial data |
| cmd_fs_i | input | 1 | Command frame strobe, high with the last bit of the previous frame |
| rd_dat_o | output | 1 | Read response serial data |
| rd_fs_o | output | 1 | Read response frame strobe |
| tx_valid_o | output | 1 | One-cycle strobe for a decoded transmit data word |
| tx_addr_o | output | 5 | Transmit data address |
| tx_updn_o | output | 1 | Up/down flag |
| tx_mode_o | output | 1 | Single/quad mode flag |
| tx_data_o | output | 8 | Transmit data byte |
| regs_o | output | NUM_REGS*8 | Register bank contents, register a in bits 8*a+7:8*a |

## Verification
Counting from the edge that samples bit 0 of a word: the transmit strobe is due one edge later, the register update and the response strobe two edges later, and the response bits at edges three through eighteen. The bench pushes the expected strobe fields and response words into queues when it starts driving each frame. Monitors running on the falling clock edge pop and compare in arrival order. They gather response bits by counting cycles from rd_fs_o, so a strobe that lands on the last bit of the previous response is still handled. Register contents are compared against a model once the traffic has drained. Aborted and stray bits are checked by showing that no strobe or response appears and that the registers keep their values.

// File: rtl/cmd_port_pkg.sv
package cmd_port_pkg;
  localparam int FRAME_W   = 16;
  localparam int ADDR_W    = 6;
  localparam int TX_ADDR_W = 5;
  localparam int DATA_W    = 8;

  typedef struct packed {
    logic              kind;   // 0: control
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } ctrl_word_t;

  typedef struct packed {
    logic                 kind;  // 1: transmit data
    logic [TX_ADDR_W-1:0] addr;
    logic                 updn;
    logic                 mode;
    logic [DATA_W-1:0]    data;
  } tx_word_t;
endpackage

// File: rtl/cmd_rx_shift.sv
module cmd_rx_shift #(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dat_i,
  input  logic               fs_i,
  output logic               frame_vld_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0]   cnt_q;
  logic               act_q;
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      act_q       <= 1'b0;
      sr_q        <= '0;
      frame_o     <= '0;
      frame_vld_o <= 1'b0;
    end else begin
      frame_vld_o <= 1'b0;
      if (act_q) begin
        sr_q  <= {sr_q[FRAME_W-2:0], dat_i};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          frame_o     <= {sr_q[FRAME_W-2:0], dat_i};
          frame_vld_o <= 1'b1;
          act_q       <= 1'b0;
        end
      end
      // strobe restarts the count; a partial frame is simply dropped
      if (fs_i) begin
        cnt_q <= '0;
        act_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmd_reg_bank.sv
module cmd_reg_bank #(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          waddr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [ADDR_W-1:0]          raddr_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[g] <= '0;
      else if (we_i && waddr_i == ADDR_W'(g))      mem_q[g] <= wdata_i;
    end
    assign regs_o[g*DATA_W +: DATA_W] = mem_q[g];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (raddr_i == ADDR_W'(i)) rdata_o = mem_q[i];
  end
endmodule

// File: rtl/rd_serializer.sv
module rd_serializer #(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic               dat_o,
  output logic               fs_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] pend_q, sr_q;
  logic               pend_vld_q, fs_q;
  logic [CNT_W-1:0]   left_q;

  // pend stage lets the strobe overlap the last bit of a running frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      sr_q       <= '0;
      left_q     <= '0;
      fs_q       <= 1'b0;
    end else begin
      fs_q <= load_i;
      if (load_i) begin
        pend_q     <= word_i;
        pend_vld_q <= 1'b1;
      end
      if (pend_vld_q) begin
        sr_q       <= pend_q;
        left_q     <= CNT_W'(FRAME_W);
        pend_vld_q <= load_i;
      end else if (left_q != '0) begin
        sr_q   <= {sr_q[FRAME_W-2:0], 1'b0};
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign dat_o = (left_q != '0) & sr_q[FRAME_W-1];
  assign fs_o  = fs_q;
endmodule

// File: rtl/cmd_port_slave.sv
module cmd_port_slave
  import cmd_port_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmd_dat_i,
  input  logic                     cmd_fs_i,
  output logic                     rd_dat_o,
  output logic                     rd_fs_o,
  output logic                     tx_valid_o,
  output logic [TX_ADDR_W-1:0]     tx_addr_o,
  output logic                     tx_updn_o,
  output logic                     tx_mode_o,
  output logic [DATA_W-1:0]        tx_data_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic               frm_vld;
  logic [FRAME_W-1:0] frm;
  ctrl_word_t         cw;
  tx_word_t           tw;
  logic               is_ctrl, reg_we, reg_re;
  logic [DATA_W-1:0]  rdata;
  logic [FRAME_W-1:0] resp;

  cmd_rx_shift #(.FRAME_W(FRAME_W)) u_rx (
    .clk_i, .rst_ni,
    .dat_i       (cmd_dat_i),
    .fs_i        (cmd_fs_i),
    .frame_vld_o (frm_vld),
    .frame_o     (frm)
  );

  assign cw      = ctrl_word_t'(frm);
  assign tw      = tx_word_t'(frm);
  assign is_ctrl = frm_vld & (cw.kind == 1'b0);
  assign reg_we  = is_ctrl & ~cw.rd;
  assign reg_re  = is_ctrl &  cw.rd;

  cmd_reg_bank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk_i, .rst_ni,
    .we_i    (reg_we),
    .waddr_i (cw.addr),
    .wdata_i (cw.data),
    .raddr_i (cw.addr),
    .rdata_o (rdata),
    .regs_o  (regs_o)
  );

  assign resp = {1'b0, 1'b1, cw.addr, rdata};

  rd_serializer #(.FRAME_W(FRAME_W)) u_rd (
    .clk_i, .rst_ni,
    .load_i (reg_re),
    .word_i (resp),
    .dat_o  (rd_dat_o),
    .fs_o   (rd_fs_o)
  );

  assign tx_valid_o = frm_vld & tw.kind;
  assign tx_addr_o  = tw.addr;
  assign tx_updn_o  = tw.updn;
  assign tx_mode_o  = tw.mode;
  assign tx_data_o  = tw.data;
endmodule

// File: rtl/cmd_port_slave_chk.sv
module cmd_port_slave_chk #(
  parameter int NUM_REGS = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  tx_valid_i,
  input logic                  rd_fs_i,
  input logic                  rd_dat_i,
  input logic [NUM_REGS*8-1:0] regs_i,
  input logic                  frm_vld_i,
  input logic [15:0]           frm_i
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!tx_valid_i && !rd_fs_i && !rd_dat_i && regs_i == '0));

  // R5
  tx_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |=> !tx_valid_i);

  // R6
  rd_fs_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fs_i |=> (!rd_fs_i && !rd_dat_i) ##1 rd_dat_i);

  // R7
  tx_no_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |=> !rd_fs_i);

  // R4
  reg0_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && !frm_i[15] && !frm_i[14] && frm_i[13:8] == 6'd0)
      |=> regs_i[7:0] == $past(frm_i[7:0]));

  // R9
  oob_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && !frm_i[15] && !frm_i[14] && frm_i[13:8] >= NUM_REGS)
      |=> $stable(regs_i));
endmodule

bind cmd_port_slave cmd_port_slave_chk #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_valid_i (tx_valid_o),
  .rd_fs_i    (rd_fs_o),
  .rd_dat_i   (rd_dat_o),
  .regs_i     (regs_o),
  .frm_vld_i  (frm_vld),
  .frm_i      (frm)
);

// File: tb/cmd_port_slave_tb_top.sv
`timescale 1ns/1ps
module cmd_port_slave_tb_top;
  localparam int NR = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_dat_i = 1'b0, cmd_fs_i = 1'b0;
  logic rd_dat_o, rd_fs_o, tx_valid_o, tx_updn_o, tx_mode_o;
  logic [4:0] tx_addr_o;
  logic [7:0] tx_data_o;
  logic [NR*8-1:0] regs_o;

  always #2 clk_i = ~clk_i;

  cmd_port_slave #(.NUM_REGS(NR)) dut_i (
    .clk_i, .rst_ni, .cmd_dat_i, .cmd_fs_i, .rd_dat_o, .rd_fs_o,
    .tx_valid_o, .tx_addr_o, .tx_updn_o, .tx_mode_o, .tx_data_o, .regs_o
  );

  int n_chk = 0, n_fail = 0, idle_err = 0, rd_left = 0;
  bit done = 1'b0;
  logic [14:0] exp_tx [$];
  logic [15:0] exp_rd [$];
  logic [7:0]  model [NR];
  logic [15:0] rd_acc, e_rd;
  logic [14:0] e_tx;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic b, input logic fs);
    cmd_dat_i = b;
    cmd_fs_i  = fs;
    @(posedge clk_i);
    #1;
  endtask

  task automatic sync();
    cyc(1'b0, 1'b1);
  endtask

  // driver: push expectations, then shift the word
  task automatic send_word(input logic [15:0] w, input logic fs_last);
    if (w[15]) exp_tx.push_back(w[14:0]);
    else if (w[14]) exp_rd.push_back({2'b01, w[13:8], (int'(w[13:8]) < NR) ? model[w[13:8]] : 8'h00});
    else if (int'(w[13:8]) < NR) model[w[13:8]] = w[7:0];
    for (int i = 15; i >= 0; i--) cyc(w[i], (i == 0) ? fs_last : 1'b0);
  endtask

  task automatic send_part(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) cyc(w[15-i], (i == n-1));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0);
  endtask

  task automatic check_regs(input string req);
    for (int a = 0; a < NR; a++) check(req, $sformatf("reg %0d", a), regs_o[a*8 +: 8], model[a]);
  endtask

  // tx monitor
  always @(negedge clk_i) if (rst_ni && tx_valid_o) begin
    if (exp_tx.size() == 0) check("R8 or R10", "unexpected tx strobe", {tx_addr_o, tx_updn_o, tx_mode_o, tx_data_o}, -1);
    else begin
      e_tx = exp_tx.pop_front();
      check("R5", "tx fields", {tx_addr_o, tx_updn_o, tx_mode_o, tx_data_o}, e_tx);
    end
  end

  // read monitor
  always @(negedge clk_i) if (rst_ni) begin
    if (rd_left > 0) begin
      rd_acc = {rd_acc[14:0], rd_dat_o};
      rd_left--;
      if (rd_left == 0) begin
        if (exp_rd.size() == 0) check("R8 or R10", "unexpected response", rd_acc, -1);
        else begin
          e_rd = exp_rd.pop_front();
          check("R6", "response frame", rd_acc, e_rd);
        end
      end
    end else if (rd_dat_o !== 1'b0) idle_err++;
    if (rd_fs_o) rd_left = 16;
  end

  initial begin
    for (int a = 0; a < NR; a++) model[a] = 8'h00;
    repeat (3) @(posedge clk_i);
    #1;
    // R1
    check("R1", "tx_valid", tx_valid_o, 0);
    check("R1", "rd_fs", rd_fs_o, 0);
    check("R1", "rd_dat", rd_dat_o, 0);
    check("R1", "regs", (regs_o == '0), 1);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1", "regs after release", (regs_o == '0), 1);

    // R2 R3 R4 R6: back-to-back mix
    sync();
    send_word({1'b0, 1'b0, 6'd3, 8'hA5}, 1'b1);
    send_word({1'b0, 1'b0, 6'd0, 8'h5A}, 1'b1);
    send_word({1'b1, 5'h15, 1'b1, 1'b0, 8'h3C}, 1'b1);
    send_word({1'b0, 1'b1, 6'd3, 8'h00}, 1'b1);
    send_word({1'b0, 1'b1, 6'd0, 8'hFF}, 1'b0);
    idle(24);
    check_regs("R4");

    // R5: flag patterns, extreme addresses
    sync();
    send_word({1'b1, 5'h00, 1'b0, 1'b1, 8'hFF}, 1'b1);
    send_word({1'b1, 5'h1F, 1'b1, 1'b1, 8'h00}, 1'b0);
    idle(6);

    // R9: out-of-range write and read; top register
    sync();
    send_word({1'b0, 1'b0, 6'd20, 8'h77}, 1'b1);
    send_word({1'b0, 1'b1, 6'd20, 8'h00}, 1'b1);
    send_word({1'b0, 1'b0, 6'd15, 8'hC3}, 1'b1);
    send_word({1'b0, 1'b1, 6'd15, 8'h00}, 1'b0);
    idle(24);
    check_regs("R9");

    // R8: early strobes abort write, read and tx frames
    sync();
    send_part({1'b0, 1'b0, 6'd1, 8'hEE}, 15);
    send_part({1'b0, 1'b1, 6'd3, 8'h00}, 9);
    send_part({1'b1, 5'h0A, 1'b1, 1'b1, 8'h81}, 1);
    send_word({1'b0, 1'b1, 6'd1, 8'h00}, 1'b0);
    idle(24);
    check("R8", "reg 1 after aborted write", regs_o[15:8], 8'h00);

    // R10: bits with no strobe after a closed frame
    for (int i = 15; i >= 0; i--) cyc(logic'(((16'h0299) >> i) & 1), 1'b0);
    for (int i = 15; i >= 0; i--) cyc(logic'(((16'hC0F0) >> i) & 1), 1'b0);
    for (int i = 15; i >= 0; i--) cyc(logic'(((16'h4300) >> i) & 1), 1'b0);
    idle(24);
    check("R10", "reg 2 untouched", regs_o[23:16], 8'h00);
    check_regs("R7");

    idle(4);
    check("R5", "tx queue drained", exp_tx.size(), 0);
    check("R6", "response queue drained", exp_rd.size(), 0);
    check("R7", "idle rd_dat violations", idle_err, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule